// File: doc/BRIEF.md
# Power-Save Processor Clock Controller

This block derives a processor clock enable and two output clock enables from one fast reference clock. Every output is a one-cycle enable pulse in the reference clock domain, so the whole block stays synchronous and synthesizable. An optional halving stage produces the full-rate tick. A power-save divider then stretches the processor tick by a power of two, from /1 up to /128. A power-save enable bit chooses between the divided tick and the full-rate tick.

Software programs the block through a simple write port: a strobe, an address and a data word. Reads are combinational on the same address. A change to the divider, the power-save enable or the halving stage waits for the end of the current processor period. Because of this, the processor never sees a shortened period. An interrupt request clears the power-save enable by itself. Full rate then resumes at the next period boundary.

Each of the two clock outputs has two controls. One selects between the full-rate tick and the processor tick. The other is a drive-disable that holds the output low. While the active-low reset is held, a 16-bit strap word is captured into a read-only register.

Top module: `psclk_ctrl`

## Requirements
- R1: While rst_ni is low, cpu_ce_o and both bits of clk_out_o are 0. After reset, address 0 reads 0 (power-save off, divisor /1, no halving) and address 1 reads 4'b0101 (both outputs enabled, both selecting the processor tick).
- R2: At every clock edge with rst_ni low, strap_i is captured. Address 2 returns the captured word, and writes to address 2 do not change it.
- R3: Address 0 holds the power-save enable in bit 3. With that enable off in the active configuration, cpu_ce_o pulses on every full-rate tick.
- R4: Address 0 holds the divisor field in bits 2:0. With power-save on, a field value n gives one cpu_ce_o pulse every 2^n full-rate ticks: 0 gives /1 and 7 gives /128.
- R5: Address 0 bit 4 enables the halving stage. When it is active, a full-rate tick occurs on every second reference clock cycle.
- R6: A write to address 0 reads back in the next cycle. It reaches the divider only on a clock edge where cpu_ce_o is 1, so the period already running keeps its length.
- R7: An interrupt request (irq_i high for one cycle) clears bit 3 of address 0, with priority over a write in the same cycle. Once the current period ends, cpu_ce_o pulses on every full-rate tick.
- R8: Address 1 holds the select bits: bit 0 for output A (clk_out_o[0]) and bit 2 for output B (clk_out_o[1]). A select bit of 1 routes the processor tick to the output and 0 routes the full-rate tick, and the two outputs are independent.
- R9: Address 1 holds the drive-disable bits: bit 1 for output A and bit 3 for output B. A disable bit of 1 holds that output at 0, whatever the other output is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Synchronous active-low reset, also strap capture window |
| strap_i | input | 16 | Strap word sampled during reset |
| irq_i | input | 1 | Interrupt request, leaves power-save |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for writes and reads |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| cpu_ce_o | output | 1 | Processor clock enable pulse |
| clk_out_o | output | 2 | Output clock enables, bit 0 is output A, bit 1 is output B |

## Verification
The bench builds the block with its default parameters: a 3-bit divisor field, a 16-bit data word and two outputs. With these values the deepest setting, /128, repeats within a couple of hundred cycles. This makes it practical to measure every divisor setting directly, to place a configuration change or an interrupt in the middle of the longest period, and to check the halving stage combined with each divisor. Randomly placed writes, interrupts and short resets are compared against a bench model on every cycle. These random events also reach reconfiguration on the exact boundary cycle and an interrupt that arrives together with a write.

// File: rtl/psclk_pkg.sv
// Package: shared register map constants for the power-save clock controller.
// Assumes addresses are compared after being cast to the address port width.
package psclk_pkg;
    localparam int unsigned ADDR_CTRL  = 0;  // divisor, power-save enable, halving
    localparam int unsigned ADDR_OUT   = 1;  // output select and drive-disable
    localparam int unsigned ADDR_STRAP = 2;  // read-only strap word
endpackage

// File: rtl/psclk_regs.sv
// Module: register file of the clock controller.
// Holds the control word and the output word, captures the strap word during
// reset, and forms the next control word (interrupt clears power-save enable).
// Assumes DATA_W is at least DIV_W+2 and at least 2*NUM_OUT.
module psclk_regs #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2,
    parameter int DIV_W   = 3,
    parameter int NUM_OUT = 2,
    localparam int CTRL_W = DIV_W + 2,
    localparam int OCFG_W = 2 * NUM_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] strap,
    input  logic              irq,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_d,
    output logic [OCFG_W-1:0] ocfg_q,
    output logic [DATA_W-1:0] rdata
);
    import psclk_pkg::*;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] strap_q;
    logic              wdata_unused;

    // Default output word: every output enabled and selecting the processor tick.
    function automatic logic [OCFG_W-1:0] ocfg_default();
        logic [OCFG_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_OUT; i++) v[2*i] = 1'b1;
        return v;
    endfunction

    assign wdata_unused = ^wdata[DATA_W-1:CTRL_W];

    // Next control word: a write replaces it, an interrupt then clears the enable.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && addr == ADDR_W'(ADDR_CTRL)) ctrl_d = wdata[CTRL_W-1:0];
        if (irq) ctrl_d[DIV_W] = 1'b0;
    end

    // Register update, with defaults and strap capture while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            ocfg_q  <= ocfg_default();
            strap_q <= strap;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_en && addr == ADDR_W'(ADDR_OUT)) ocfg_q <= wdata[OCFG_W-1:0];
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL))       rdata = DATA_W'(ctrl_q);
        else if (addr == ADDR_W'(ADDR_OUT))   rdata = DATA_W'(ocfg_q);
        else if (addr == ADDR_W'(ADDR_STRAP)) rdata = strap_q;
    end
endmodule

// File: rtl/psclk_div.sv
// Module: halving stage and power-save divider.
// Produces the full-rate tick and the processor tick. The active configuration
// loads only on a processor tick, so a running period is never cut short.
// Assumes the divisor field encodes a power of two up to 2^(2^DIV_W - 1).
module psclk_div #(
    parameter int DIV_W  = 3,
    localparam int CTRL_W = DIV_W + 2,
    localparam int CNT_W  = (1 << DIV_W) - 1,
    localparam int SPAN_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_d,
    output logic              base_tick,
    output logic              cpu_tick
);
    logic [CTRL_W-1:0] act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              phase_q;
    logic [SPAN_W-1:0] span;
    logic [CNT_W-1:0]  last;
    logic [DIV_W-1:0]  act_div;
    logic              act_ps;
    logic              act_pre;

    assign act_div = act_q[DIV_W-1:0];
    assign act_ps  = act_q[DIV_W];
    assign act_pre = act_q[DIV_W+1];

    // Tick generation: full-rate tick, period length, and end-of-period tick.
    always_comb begin
        base_tick = !act_pre || phase_q;
        span      = SPAN_W'(1) << act_div;
        last      = act_ps ? CNT_W'(span - SPAN_W'(1)) : '0;
        cpu_tick  = base_tick && (cnt_q == last);
    end

    // Phase toggle, period counter and boundary load of the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            phase_q <= !phase_q;
            if (cpu_tick) begin
                cnt_q <= '0;
                act_q <= ctrl_d;
            end else if (base_tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/psclk_outsel.sv
// Module: output clock selection and drive-disable, one slice per output.
// Bit 2i of the output word selects the processor tick, bit 2i+1 disables.
// Assumes outputs are forced low during reset by the rst_n gate.
module psclk_outsel #(
    parameter int NUM_OUT = 2,
    localparam int OCFG_W = 2 * NUM_OUT
) (
    input  logic               rst_n,
    input  logic               base_tick,
    input  logic               cpu_tick,
    input  logic [OCFG_W-1:0]  ocfg,
    output logic [NUM_OUT-1:0] clk_out
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        // Per-output mux and disable gate.
        always_comb clk_out[i] = rst_n && !ocfg[2*i+1] &&
                                 (ocfg[2*i] ? cpu_tick : base_tick);
    end
endmodule

// File: rtl/psclk_ctrl.sv
// Module: top of the power-save clock controller.
// Connects the register file, the divider and the output selection. All
// outputs are clock-enable pulses in the clk_i domain.
// Assumes the reference clock and the register port share clk_i.
module psclk_ctrl #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2,
    parameter int DIV_W   = 3,
    parameter int NUM_OUT = 2,
    localparam int CTRL_W = DIV_W + 2,
    localparam int OCFG_W = 2 * NUM_OUT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DATA_W-1:0]  strap_i,
    input  logic               irq_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               cpu_ce_o,
    output logic [NUM_OUT-1:0] clk_out_o
);
    logic [CTRL_W-1:0] ctrl_d;
    logic [OCFG_W-1:0] ocfg_q;
    logic              base_tick;
    logic              cpu_tick;

    psclk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .NUM_OUT(NUM_OUT)) u_regs (
        .clk(clk_i), .rst_n(rst_ni), .strap(strap_i), .irq(irq_i), .wr_en(wr_en_i),
        .addr(addr_i), .wdata(wdata_i), .ctrl_d(ctrl_d), .ocfg_q(ocfg_q), .rdata(rdata_o)
    );

    psclk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk_i), .rst_n(rst_ni), .ctrl_d(ctrl_d),
        .base_tick(base_tick), .cpu_tick(cpu_tick)
    );

    psclk_outsel #(.NUM_OUT(NUM_OUT)) u_out (
        .rst_n(rst_ni), .base_tick(base_tick), .cpu_tick(cpu_tick),
        .ocfg(ocfg_q), .clk_out(clk_out_o)
    );

    // Processor enable, held low during reset.
    always_comb cpu_ce_o = rst_ni && cpu_tick;
endmodule

// File: rtl/psclk_ctrl_chk.sv
// Module: assertion checker for psclk_ctrl, attached by bind.
// Assumes address 2 is the strap register and output bits are laid out as
// select at 2i and disable at 2i+1.
module psclk_ctrl_chk #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2,
    parameter int NUM_OUT = 2,
    localparam int OCFG_W = 2 * NUM_OUT
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  strap,
    input logic [DATA_W-1:0]  rdata,
    input logic               cpu_ce,
    input logic [NUM_OUT-1:0] clk_out,
    input logic               base_tick,
    input logic [OCFG_W-1:0]  ocfg
);
    // Outputs stay quiet while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_quiet_r1: assert (!cpu_ce && clk_out == '0);
        end
    end

    // The word present during the last reset edge reads back at address 2.
    p_strap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && addr == ADDR_W'(2)) |-> rdata == $past(strap));

    // An interrupt on a boundary edge leaves full rate for the following period.
    p_irq_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cpu_ce) |=> (!base_tick || cpu_ce));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
        // A disabled output never pulses.
        p_dis_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ocfg[2*i+1] |-> !clk_out[i]);
        // An enabled output selecting full rate follows the full-rate tick.
        p_full_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!ocfg[2*i+1] && !ocfg[2*i]) |-> clk_out[i] == base_tick);
    end
endmodule

bind psclk_ctrl psclk_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .irq(irq_i), .addr(addr_i), .strap(strap_i),
    .rdata(rdata_o), .cpu_ce(cpu_ce_o), .clk_out(clk_out_o),
    .base_tick(base_tick), .ocfg(ocfg_q)
);

// File: tb/psclk_ctrl_tb_top.sv
// Bench for psclk_ctrl: directed corner cases plus seeded random traffic,
// compared every cycle against a bench model of the requirements.
module psclk_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] strap = 16'h0000;
    logic        irq = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        cpu_ce;
    logic [1:0]  clk_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // Bench model state.
    logic [2:0]  m_div, a_div;
    logic        m_ps, a_ps, m_pre, a_pre, m_ph;
    logic [3:0]  m_oc;
    logic [15:0] m_strap;
    int          m_cnt;

    always #10 clk = !clk;

    psclk_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap), .irq_i(irq), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cpu_ce_o(cpu_ce), .clk_out_o(clk_out)
    );

    function automatic logic e_base();
        return !a_pre || m_ph;
    endfunction

    function automatic logic e_cpu_raw();
        int per;
        per = a_ps ? (1 << a_div) : 1;
        return e_base() && (m_cnt == per - 1);
    endfunction

    function automatic logic e_out(int i);
        logic src;
        src = m_oc[2*i] ? e_cpu_raw() : e_base();
        return rst_ni && !m_oc[2*i+1] && src;
    endfunction

    function automatic logic [15:0] e_rdata(logic [1:0] a);
        case (a)
            2'd0:    return {11'd0, m_pre, m_ps, m_div};
            2'd1:    return {12'd0, m_oc};
            2'd2:    return m_strap;
            default: return 16'd0;
        endcase
    endfunction

    // Model update on each edge, from the inputs applied since the last negedge.
    always @(posedge clk) begin
        logic t, b;
        if (!rst_ni) begin
            m_div = 0; m_ps = 0; m_pre = 0; a_div = 0; a_ps = 0; a_pre = 0;
            m_ph = 0; m_oc = 4'b0101; m_cnt = 0; m_strap = strap;
        end else begin
            t = e_cpu_raw();
            b = e_base();
            if (wr_en && addr == 2'd0) {m_pre, m_ps, m_div} = wdata[4:0];
            if (wr_en && addr == 2'd1) m_oc = wdata[3:0];
            if (irq) m_ps = 1'b0;
            m_ph = !m_ph;
            if (t) begin
                m_cnt = 0; a_div = m_div; a_ps = m_ps; a_pre = m_pre;
            end else if (b) begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk(cur_tag, 32'(cpu_ce), 32'(rst_ni && e_cpu_raw()));
        chk("R8", 32'(clk_out[0]), 32'(e_out(0)));
        chk("R8", 32'(clk_out[1]), 32'(e_out(1)));
        chk("R6", 32'(rdata), 32'(e_rdata(addr)));
    endtask

    task automatic step(logic w, logic [1:0] a, logic [15:0] d, logic q);
        wr_en = w; addr = a; wdata = d; irq = q;
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 16'd0, 1'b0);
    endtask

    // Steps until the next cpu_ce pulse, then counts steps to the following one.
    task automatic meas(output int p);
        int n;
        n = 0;
        while (!cpu_ce && n < 400) begin idle(); n++; end
        n = 0;
        do begin idle(); n++; end while (!cpu_ce && n < 400);
        p = n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p, n, pulses, aseen;
        void'($urandom(32'd2024));
        strap = 16'hA5C3;
        repeat (3) begin
            @(negedge clk);
            chk("R1", 32'({cpu_ce, clk_out}), 32'd0);
        end
        rst_ni = 1'b1;
        step(1'b0, 2'd2, 16'd0, 1'b0);
        chk("R2", 32'(rdata), 32'hA5C3);
        step(1'b0, 2'd0, 16'd0, 1'b0);
        chk("R1", 32'(rdata), 32'd0);
        step(1'b0, 2'd1, 16'd0, 1'b0);
        chk("R1", 32'(rdata), 32'h5);
        step(1'b1, 2'd2, 16'h1234, 1'b0);
        step(1'b0, 2'd2, 16'd0, 1'b0);
        chk("R2", 32'(rdata), 32'hA5C3);

        cur_tag = "R3";
        meas(p);
        chk("R3", 32'(p), 32'd1);

        cur_tag = "R4";
        for (int d = 0; d < 8; d++) begin
            step(1'b1, 2'd0, 16'(8 + d), 1'b0);
            meas(p);
            meas(p);
            chk("R4", 32'(p), 32'(1 << d));
        end

        cur_tag = "R5";
        step(1'b1, 2'd0, 16'h10, 1'b0);
        meas(p); meas(p);
        chk("R5", 32'(p), 32'd2);
        step(1'b1, 2'd0, 16'h19, 1'b0);
        meas(p); meas(p);
        chk("R5", 32'(p), 32'd4);

        cur_tag = "R6";
        step(1'b1, 2'd0, 16'h0F, 1'b0);
        meas(p); meas(p);
        idle();
        step(1'b1, 2'd0, 16'h08, 1'b0);
        chk("R6", 32'(rdata), 32'h08);
        n = 1;
        while (!cpu_ce && n < 400) begin idle(); n++; end
        chk("R6", 32'(n), 32'd127);
        meas(p);
        chk("R6", 32'(p), 32'd1);

        cur_tag = "R7";
        step(1'b1, 2'd0, 16'h0F, 1'b0);
        meas(p); meas(p);
        repeat (10) idle();
        step(1'b1, 2'd0, 16'h0F, 1'b1);
        chk("R7", 32'(rdata[3]), 32'd0);
        n = 0;
        while (!cpu_ce && n < 400) begin idle(); n++; end
        chk("R7", 32'(n), 32'd117);
        meas(p);
        chk("R7", 32'(p), 32'd1);

        cur_tag = "R8";
        step(1'b1, 2'd0, 16'h0A, 1'b0);
        step(1'b1, 2'd1, 16'h4, 1'b0);
        meas(p); meas(p);
        pulses = 0; aseen = 0;
        repeat (16) begin idle(); pulses += clk_out[1]; aseen += clk_out[0]; end
        chk("R8", 32'(pulses), 32'd4);
        chk("R8", 32'(aseen), 32'd16);
        step(1'b1, 2'd1, 16'h6, 1'b0);
        pulses = 0; aseen = 0;
        repeat (16) begin idle(); pulses += clk_out[1]; aseen += clk_out[0]; end
        chk("R9", 32'(aseen), 32'd0);
        chk("R9", 32'(pulses), 32'd4);
        step(1'b1, 2'd1, 16'hC, 1'b0);
        pulses = 0; aseen = 0;
        repeat (16) begin idle(); pulses += clk_out[1]; aseen += clk_out[0]; end
        chk("R9", 32'(pulses), 32'd0);
        chk("R9", 32'(aseen), 32'd16);

        cur_tag = "R4";
        for (int k = 0; k < 5000; k++) begin
            int r;
            r = int'($urandom_range(0, 999));
            if (r < 4) begin
                rst_ni = 1'b0;
                strap = 16'($urandom);
                step(1'b0, 2'd2, 16'd0, 1'b0);
                step(1'b0, 2'd2, 16'd0, 1'b0);
                rst_ni = 1'b1;
            end else if (r < 90) begin
                step(1'b1, 2'($urandom_range(0, 3)), 16'($urandom),
                     ($urandom_range(0, 3) == 0));
            end else if (r < 110) begin
                step(1'b0, 2'($urandom_range(0, 3)), 16'd0, 1'b1);
            end else begin
                step(1'b0, 2'($urandom_range(0, 3)), 16'd0, 1'b0);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule